// File: doc/BRIEF.md
# Flash Row Program Controller with Key Unlock

This block programs one row of non-volatile memory by copying it, word by word, from a RAM source region to a flash target region. Software reaches it through a simple 32-bit register bus. The bus exposes a control register, an alias of that register that only sets bits, a key register, a target row address and a source address. The copy drives a plain read port towards the source memory, with data returned one cycle after the request, and a plain write port towards the flash array.

A start request is honoured only when all of the following hold: a two-word key sequence has just unlocked the controller, write enable is set, the operation code selects row programming, the low-voltage flag is clear, and a settling interval has passed since write enable went high. Any other start request is dropped and raises a sticky error flag. The start bit stays high while the copy runs and drops by itself at the end, so software polls it. Every start attempt locks the controller again.

Top module: `flash_row_prog`

## Requirements
- R1: After reset the control register reads 0, both address registers read 0, and neither memory port is active.
- R2: The target address register (offset 0x20) and the source address register (offset 0x40) read back what was written. The key register (offset 0x10) always reads 0.
- R3: The control register (offset 0x00) has this layout: bit 15 is the start/busy bit, bit 14 is write enable, bit 13 is the sticky error flag, bit 11 mirrors the `lvd_in` pin, and bits 3:0 hold the operation code. Code 3 selects row programming. A write of 0x4003 reads back 0x4003 while `lvd_in` is low.
- R4: The controller unlocks when key 0xAA996655 is written and then key 0x556699AA is written as the very next bus access. Any other bus access in between, read or write, relocks it. A start request while locked is rejected and sets bit 13.
- R5: A write to the set alias (offset 0x08) ORs the written bits into write enable, the error flag and the operation code, and clears none of them. Bit 15 written there is a start request.
- R6: A start request is rejected, with bit 13 set, unless at least SETUP_CYCLES clock cycles have passed since the write that raised write enable.
- R7: An accepted row program performs ROW_WORDS steps, with i running upward from 0. In step i the controller reads source address `src+4*i`, and in the following cycle it writes the returned data to target address `dst+4*i`. Each word takes two cycles.
- R8: Bit 15 reads 1 from the cycle after the accepted start until the last destination write, and reads 0 in the cycle after that write.
- R9: A start request while `lvd_in` is high is rejected and sets bit 13.
- R10: While bit 15 is set, bus writes to the control, set-alias, key and address registers have no effect.
- R11: Every start request, whether accepted or rejected, relocks the controller, so each operation needs a fresh key sequence.
- R12: A start request while write enable is clear, or while the operation code is not 3, is rejected and sets bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| lvd_in | input | 1 | Low-voltage flag from the supply monitor |
| src_rd_en | output | 1 | Source memory read request |
| src_rd_addr | output | MEM_AW | Source byte address |
| src_rd_data | input | 32 | Source data, valid the cycle after the request |
| dst_wr_en | output | 1 | Flash write strobe |
| dst_wr_addr | output | MEM_AW | Flash target byte address |
| dst_wr_data | output | 32 | Flash write data |

## Verification
The assertions check on every cycle the rules that tie the copy to its admission. A destination write always follows a source read and never coincides with one. The busy bit only rises from the unlocked state with the low-voltage flag clear. The address registers hold steady while busy, the controller is never unlocked during a copy, and busy ends on a destination write. The bench scenarios cover the rest: the exact key sequence and the ways it breaks, the settling interval after write enable, the set-alias merge, and whether each rejection is sticky. Its per-cycle reference model also confirms every address and data word of the copy and every register read.

// File: rtl/flash_row_pkg.sv
package flash_row_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 4;

    // Register offsets
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_SET  = 8'h08;
    localparam logic [7:0] OFS_KEY  = 8'h10;
    localparam logic [7:0] OFS_DST  = 8'h20;
    localparam logic [7:0] OFS_SRC  = 8'h40;

    // Control bit positions
    localparam int BIT_BUSY = 15;
    localparam int BIT_WEN  = 14;
    localparam int BIT_ERR  = 13;
    localparam int BIT_LVD  = 11;

    localparam logic [OP_W-1:0] OP_ROW_PROG = 4'd3;

    localparam logic [DATA_W-1:0] UNLOCK_KEY_A = 32'hAA99_6655;
    localparam logic [DATA_W-1:0] UNLOCK_KEY_B = 32'h5566_99AA;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            wen;
        logic            err;
        logic [OP_W-1:0] op;
    } ctrl_t;

endpackage

// File: rtl/flash_key_unlock.sv
module flash_key_unlock
    import flash_row_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic key_a_wr,
    input  logic key_other_wr,
    input  logic key_b_wr,
    input  logic start_try,
    output logic unlocked
);

    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_HALF: begin
                if (key_a_wr)      state_d = KS_HALF;
                else if (key_b_wr) state_d = KS_OPEN;
                else if (access)   state_d = KS_LOCKED;
            end
            KS_OPEN: begin
                if (key_a_wr)                              state_d = KS_HALF;
                else if (key_b_wr || key_other_wr || start_try) state_d = KS_LOCKED;
            end
            default: begin
                if (key_a_wr) state_d = KS_HALF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);

endmodule

// File: rtl/flash_setup_timer.sv
module flash_setup_timer #(
    parameter int SETUP_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wen_next,
    input  logic wen_rise,
    output logic elapsed
);

    localparam int CNT_W = $clog2(SETUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETUP_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wen_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!wen_next || wen_rise) cnt_d = '0;
        else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wen_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            wen_q <= wen_next;
        end
    end

    assign elapsed = wen_q && (cnt_q == CNT_MAX);

endmodule

// File: rtl/flash_row_seq.sv
module flash_row_seq
    import flash_row_pkg::*;
#(
    parameter int ROW_WORDS = 128,
    parameter int MEM_AW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MEM_AW-1:0] src_base,
    input  logic [MEM_AW-1:0] dst_base,
    output logic              busy,
    output logic              src_rd_en,
    output logic [MEM_AW-1:0] src_rd_addr,
    input  logic [DATA_W-1:0] src_rd_data,
    output logic              dst_wr_en,
    output logic [MEM_AW-1:0] dst_wr_addr,
    output logic [DATA_W-1:0] dst_wr_data
);

    localparam int IDX_W = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROW_WORDS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;
    logic [MEM_AW-1:0] byte_ofs;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_READ:  s_d.st = SQ_WRITE;
            SQ_WRITE: begin
                if (s_q.idx == IDX_LAST) begin
                    s_d.st  = SQ_IDLE;
                    s_d.idx = '0;
                end else begin
                    s_d.st  = SQ_READ;
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: begin
                if (start) begin
                    s_d.st  = SQ_READ;
                    s_d.idx = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SQ_IDLE;
            s_q.idx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_ofs    = MEM_AW'(s_q.idx) << 2;
    assign busy        = (s_q.st != SQ_IDLE);
    assign src_rd_en   = (s_q.st == SQ_READ);
    assign src_rd_addr = src_base + byte_ofs;
    assign dst_wr_en   = (s_q.st == SQ_WRITE);
    assign dst_wr_addr = dst_base + byte_ofs;
    assign dst_wr_data = src_rd_data;

endmodule

// File: rtl/flash_row_prog.sv
module flash_row_prog
    import flash_row_pkg::*;
#(
    parameter int ROW_WORDS    = 128,
    parameter int SETUP_CYCLES = 600,
    parameter int BUS_AW       = 8,
    parameter int MEM_AW       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              lvd_in,
    output logic              src_rd_en,
    output logic [MEM_AW-1:0] src_rd_addr,
    input  logic [31:0]       src_rd_data,
    output logic              dst_wr_en,
    output logic [MEM_AW-1:0] dst_wr_addr,
    output logic [31:0]       dst_wr_data
);

    typedef struct packed {
        ctrl_t             ctl;
        logic [MEM_AW-1:0] dst;
        logic [MEM_AW-1:0] src;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_ctrl, hit_set, hit_key, hit_dst, hit_src;
    logic wr_ok, start_try, start_ok, wen_rise;
    logic key_a_wr, key_b_wr, key_other_wr;
    logic seq_busy, key_unlocked, setup_done;
    logic [MEM_AW-1:0] dst_base, src_base;

    assign hit_ctrl = (bus_addr == BUS_AW'(OFS_CTRL));
    assign hit_set  = (bus_addr == BUS_AW'(OFS_SET));
    assign hit_key  = (bus_addr == BUS_AW'(OFS_KEY));
    assign hit_dst  = (bus_addr == BUS_AW'(OFS_DST));
    assign hit_src  = (bus_addr == BUS_AW'(OFS_SRC));

    assign wr_ok        = bus_wr && !seq_busy;
    assign key_a_wr     = wr_ok && hit_key && (bus_wdata == UNLOCK_KEY_A);
    assign key_b_wr     = wr_ok && hit_key && (bus_wdata == UNLOCK_KEY_B);
    assign key_other_wr = wr_ok && hit_key && !key_a_wr && !key_b_wr;
    assign start_try    = wr_ok && (hit_ctrl || hit_set) && bus_wdata[BIT_BUSY];
    assign start_ok     = start_try && key_unlocked && r_q.ctl.wen &&
                          (r_q.ctl.op == OP_ROW_PROG) && setup_done && !lvd_in;

    always_comb begin
        r_d = r_q;
        if (wr_ok && hit_ctrl) begin
            r_d.ctl.wen = bus_wdata[BIT_WEN];
            r_d.ctl.err = bus_wdata[BIT_ERR];
            r_d.ctl.op  = bus_wdata[OP_W-1:0];
        end else if (wr_ok && hit_set) begin
            r_d.ctl.wen = r_q.ctl.wen | bus_wdata[BIT_WEN];
            r_d.ctl.err = r_q.ctl.err | bus_wdata[BIT_ERR];
            r_d.ctl.op  = r_q.ctl.op  | bus_wdata[OP_W-1:0];
        end
        if (wr_ok && hit_dst) r_d.dst = bus_wdata[MEM_AW-1:0];
        if (wr_ok && hit_src) r_d.src = bus_wdata[MEM_AW-1:0];
        if (start_try && !start_ok) r_d.ctl.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wen_rise = r_d.ctl.wen && !r_q.ctl.wen;
    assign dst_base = r_q.dst;
    assign src_base = r_q.src;

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl || hit_set) begin
            bus_rdata[BIT_BUSY]   = seq_busy;
            bus_rdata[BIT_WEN]    = r_q.ctl.wen;
            bus_rdata[BIT_ERR]    = r_q.ctl.err;
            bus_rdata[BIT_LVD]    = lvd_in;
            bus_rdata[OP_W-1:0]   = r_q.ctl.op;
        end else if (hit_dst) begin
            bus_rdata = 32'(r_q.dst);
        end else if (hit_src) begin
            bus_rdata = 32'(r_q.src);
        end
    end

    flash_key_unlock u_unlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .access       (bus_wr || bus_rd),
        .key_a_wr     (key_a_wr),
        .key_other_wr (key_other_wr),
        .key_b_wr     (key_b_wr),
        .start_try    (start_try),
        .unlocked     (key_unlocked)
    );

    flash_setup_timer #(
        .SETUP_CYCLES (SETUP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen_next (r_d.ctl.wen),
        .wen_rise (wen_rise),
        .elapsed  (setup_done)
    );

    flash_row_seq #(
        .ROW_WORDS (ROW_WORDS),
        .MEM_AW    (MEM_AW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_ok),
        .src_base    (src_base),
        .dst_base    (dst_base),
        .busy        (seq_busy),
        .src_rd_en   (src_rd_en),
        .src_rd_addr (src_rd_addr),
        .src_rd_data (src_rd_data),
        .dst_wr_en   (dst_wr_en),
        .dst_wr_addr (dst_wr_addr),
        .dst_wr_data (dst_wr_data)
    );

endmodule

// File: rtl/flash_row_prog_chk.sv
module flash_row_prog_chk #(
    parameter int MEM_AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_rd_en,
    input logic              dst_wr_en,
    input logic              busy,
    input logic              unlocked,
    input logic              lvd_in,
    input logic [MEM_AW-1:0] dst_base,
    input logic [MEM_AW-1:0] src_base
);

    assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |=> dst_wr_en);

    assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> ($past(src_rd_en) && !src_rd_en));

    assert_busy_from_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(unlocked));

    assert_busy_lvd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(lvd_in));

    assert_locked_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !unlocked);

    assert_bases_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(dst_base) && $stable(src_base)));

    assert_end_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(dst_wr_en));

endmodule

bind flash_row_prog flash_row_prog_chk #(
    .MEM_AW (MEM_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_rd_en (src_rd_en),
    .dst_wr_en (dst_wr_en),
    .busy      (seq_busy),
    .unlocked  (key_unlocked),
    .lvd_in    (lvd_in),
    .dst_base  (dst_base),
    .src_base  (src_base)
);

// File: tb/flash_row_prog_tb.sv
module flash_row_prog_tb;

    localparam int ROW   = 16;
    localparam int SETUP = 40;
    localparam logic [31:0] KA = 32'hAA99_6655;
    localparam logic [31:0] KB = 32'h5566_99AA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        lvd_in = 1'b0;
    logic        src_rd_en, dst_wr_en;
    logic [31:0] src_rd_addr, dst_wr_addr, dst_wr_data;
    logic [31:0] src_rd_data = '0;

    logic [31:0] src_mem [256];
    logic [31:0] dst_mem [256];

    int n_chk = 0, n_err = 0, cyc = 0, wr_count = 0;

    always #5 clk = ~clk;

    flash_row_prog #(.ROW_WORDS(ROW), .SETUP_CYCLES(SETUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lvd_in(lvd_in), .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr),
        .src_rd_data(src_rd_data), .dst_wr_en(dst_wr_en),
        .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data));

    always @(posedge clk) begin
        if (src_rd_en) src_rd_data <= src_mem[src_rd_addr[9:2]];
        if (dst_wr_en) begin
            dst_mem[dst_wr_addr[9:2]] <= dst_wr_data;
            wr_count <= wr_count + 1;
        end
    end

    // Behavioural reference model, evaluated at each falling edge
    int          m_phase, m_idx, m_key, m_edge, m_wen_edge;
    logic        m_wen, m_err;
    logic [3:0]  m_op;
    logic [31:0] m_dst, m_src;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v = '0;
        if (a == 8'h00 || a == 8'h08) begin
            v[15] = (m_phase != 0); v[14] = m_wen; v[13] = m_err;
            v[11] = lvd_in; v[3:0] = m_op;
        end else if (a == 8'h20) v = m_dst;
        else if (a == 8'h40) v = m_src;
        return v;
    endfunction

    task automatic cmp(input logic [31:0] got, input logic [31:0] exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_key = 0; m_edge = 1; m_wen_edge = 0;
            m_wen = 0; m_err = 0; m_op = 0; m_dst = 0; m_src = 0;
        end else begin
            logic busy0, wr_ok, try_s, ok_s;
            cmp(32'(src_rd_en), 32'(m_phase == 1), "R7 src_rd_en");
            cmp(32'(dst_wr_en), 32'(m_phase == 2), "R7 dst_wr_en");
            if (m_phase == 1) cmp(src_rd_addr, m_src + 32'(4 * m_idx), "R7 src_rd_addr");
            if (m_phase == 2) begin
                cmp(dst_wr_addr, m_dst + 32'(4 * m_idx), "R7 dst_wr_addr");
                cmp(dst_wr_data, src_mem[8'((m_src >> 2) + 32'(m_idx))], "R7 dst_wr_data");
            end
            if (bus_rd) cmp(bus_rdata, m_read(bus_addr), "R3 model readback");

            busy0 = (m_phase != 0);
            if (m_phase == 1) m_phase = 2;
            else if (m_phase == 2) begin
                if (m_idx == ROW - 1) begin m_phase = 0; m_idx = 0; end
                else begin m_idx++; m_phase = 1; end
            end

            wr_ok = bus_wr && !busy0;
            try_s = wr_ok && (bus_addr == 8'h00 || bus_addr == 8'h08) && bus_wdata[15];
            ok_s  = try_s && (m_key == 2) && m_wen && (m_op == 4'd3) && !lvd_in &&
                    (m_edge - 1 - m_wen_edge >= SETUP);

            if (wr_ok && bus_addr == 8'h10 && bus_wdata == KA) m_key = 1;
            else if (m_key == 1) begin
                if (wr_ok && bus_addr == 8'h10 && bus_wdata == KB) m_key = 2;
                else if (bus_wr || bus_rd) m_key = 0;
            end else if (m_key == 2) begin
                if ((wr_ok && bus_addr == 8'h10) || try_s) m_key = 0;
            end

            if (wr_ok && bus_addr == 8'h00) begin
                if (bus_wdata[14] && !m_wen) m_wen_edge = m_edge;
                m_wen = bus_wdata[14]; m_err = bus_wdata[13]; m_op = bus_wdata[3:0];
            end else if (wr_ok && bus_addr == 8'h08) begin
                if (bus_wdata[14] && !m_wen) m_wen_edge = m_edge;
                m_wen |= bus_wdata[14]; m_err |= bus_wdata[13]; m_op |= bus_wdata[3:0];
            end
            if (wr_ok && bus_addr == 8'h20) m_dst = bus_wdata;
            if (wr_ok && bus_addr == 8'h40) m_src = bus_wdata;
            if (try_s && !ok_s) m_err = 1;
            if (ok_s) begin m_phase = 1; m_idx = 0; end
            m_edge++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string what);
        logic [31:0] v;
        rd(a, v);
        cmp(v, exp, what);
    endtask

    task automatic unlock();
        wr(8'h10, KA);
        wr(8'h10, KB);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 200; k++) begin
            rd(8'h00, v);
            if (!v[15]) break;
        end
    endtask

    task automatic check_copy(input int s_word, input int d_word, input string what);
        for (int i = 0; i < ROW; i++)
            cmp(dst_mem[8'(d_word + i)], src_mem[8'(s_word + i)], what);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int w0;
        for (int i = 0; i < 256; i++) begin
            src_mem[i] = 32'h1000_0000 + 32'(i * 32'h0101_0103);
            dst_mem[i] = 32'hFFFF_FFFF;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1 ctrl after reset");
        rd_chk(8'h20, 32'h0, "R1 dst after reset");
        cmp(32'(src_rd_en | dst_wr_en), 0, "R1 ports idle");

        // R2 address registers and key read
        wr(8'h20, 32'h100);
        wr(8'h40, 32'h040);
        rd_chk(8'h20, 32'h100, "R2 dst readback");
        rd_chk(8'h40, 32'h040, "R2 src readback");
        rd_chk(8'h10, 32'h0, "R2 key reads zero");

        // R12 start with write enable clear
        unlock();
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'h2000, "R12 start with wen clear rejected");

        // R4 start while locked
        wr(8'h00, 32'h4003);
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'h6003, "R4 locked start rejected");

        // R3 layout, R5 set alias merges
        wr(8'h00, 32'h4001);
        wr(8'h08, 32'h0002);
        rd_chk(8'h00, 32'h4003, "R5 set alias ORs bits");
        rd_chk(8'h00, 32'h4003, "R3 ctrl readback");
        repeat (SETUP + 5) @(posedge clk);

        // R4 broken key sequence
        wr(8'h10, KA);
        rd_chk(8'h20, 32'h100, "R4 interleaved read");
        wr(8'h10, KB);
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'h6003, "R4 broken unlock rejected");
        wr(8'h00, 32'h4003);

        // R9 low voltage
        lvd_in = 1;
        rd_chk(8'h00, 32'h4803, "R3 lvd mirror");
        unlock();
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'h6803, "R9 start with lvd rejected");
        lvd_in = 0;
        wr(8'h00, 32'h4003);

        // R12 wrong op code
        wr(8'h00, 32'h4001);
        unlock();
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'h6001, "R12 wrong op rejected");
        wr(8'h00, 32'h4003);

        // accepted row program
        w0 = wr_count;
        unlock();
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'hC003, "R8 busy set after start");
        // R10 writes ignored while busy
        wr(8'h20, 32'h200);
        wr(8'h40, 32'h000);
        wr(8'h10, KA);
        wr(8'h00, 32'h0);
        wait_idle();
        rd_chk(8'h00, 32'h4003, "R8 start bit cleared, R10 ctrl kept");
        rd_chk(8'h20, 32'h100, "R10 dst kept");
        rd_chk(8'h40, 32'h040, "R10 src kept");
        cmp(32'(wr_count - w0), ROW, "R7 write count");
        check_copy(16, 64, "R7 copied row");

        // R10 key write during busy ignored, R11 relocked
        wr(8'h10, KB);
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'h6003, "R11 relocked after operation");
        cmp(32'(wr_count - w0), ROW, "R11 no extra writes");

        // R6 early start
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h4003);
        unlock();
        wr(8'h08, 32'h8000);
        rd_chk(8'h00, 32'h6003, "R6 early start rejected");
        repeat (SETUP + 5) @(posedge clk);
        wr(8'h00, 32'h4003);
        wr(8'h20, 32'h300);
        wr(8'h40, 32'h180);
        w0 = wr_count;
        unlock();
        wr(8'h00, 32'hC003);
        wait_idle();
        rd_chk(8'h00, 32'h4003, "R8 second op finished");
        cmp(32'(wr_count - w0), ROW, "R7 second write count");
        check_copy(96, 192, "R7 second row");

        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule